// File: doc/BRIEF.md
# Sticky Event Interrupt Controller

This block gathers single-cycle or level event signals from on-chip monitors, for example range alarms on the threshold and delta laser current words, and holds each one in a sticky flag until the host reads the flag register. Every flag has a per-bit enable. When any flag that is also enabled is set, the block pulls its request line low. The line is active low and is meant for an open-drain pad, so several devices can share one wired request line.

A second, read-only view returns live condition levels. The host can poll these without latching anything and without touching the request line. The host bus gives single-cycle read and write strobes, a two-bit register select, write data for the enable register, and registered read data that is valid in the cycle after the read strobe. A synchronous soft reset clears the flags and the enables.

Top module: `irq_status_ctrl`

## Requirements
- R1: During and straight after the asynchronous reset, `irq_n` is 1, `reg_rdata` is 0, and both the flag register and the enable register read back as 0.
- R2: When `evt_src[i]` rises (low in one cycle, high in the next sampled cycle), flag i is set at that clock edge. It stays set until it is cleared. A source that stays high does not set the flag again after a clearing read.
- R3: A read strobe with select 2'b00 puts the flag register on `reg_rdata`, zero-extended, after the next clock edge. The same edge clears every flag that was set.
- R4: An event that rises in the same cycle as a clearing flag read is not in that read's data. It stays latched and is returned by the next flag read.
- R5: A write strobe with select 2'b01 loads `reg_wdata` into the enable register. A read with select 2'b01 returns that value.
- R6: `irq_n` is a registered output. It is 0 one clock after the AND of flags and enables is non-zero, and 1 one clock after it is zero. A flag whose enable bit is 0 still latches but does not pull the line low.
- R7: A read with select 2'b10 returns `sts_src` as sampled at the read edge. A read of the status register or the enable register leaves the flags unchanged.
- R8: A cycle with `soft_rst` high clears all flags and all enables at that edge, and `irq_n` returns to 1 one clock later.
- R9: Writes with select 2'b00, 2'b10 or 2'b11 change no register. A read with select 2'b11 returns 0.
- R10: A source that is already high when the reset is released does not set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of flags and enables |
| evt_src | input | N_EVT | Event sources, one per flag |
| sts_src | input | N_STS | Live condition levels for polling |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 2 | Register select: 00 flags, 01 enable, 10 status, 11 unused |
| reg_wdata | input | N_EVT | Host write data |
| reg_rdata | output | max(N_EVT,N_STS) | Registered read data |
| irq_n | output | 1 | Request line, active low, drives an open-drain pad |

## Verification
A flag lost or set twice appears in the data of the next flag read. Such a read is the only way to see it when its enable is 0. With the enable set, it also appears on `irq_n` exactly one clock after the flag changes. A corrupted enable bit shows on `irq_n` one clock after the next event on that bit, and in any enable read-back. A flag that is not cleared keeps `irq_n` low one cycle past the point where it should release, and returns again in the following read. The sweep tries every enable mask against every event pattern, so any bit-level mix-up shows within a few cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned IRQC_SEL_W = 2;
   typedef enum logic [IRQC_SEL_W-1:0] {
      SEL_FLAGS = 2'b00,
      SEL_MASK  = 2'b01,
      SEL_LIVE  = 2'b10,
      SEL_NONE  = 2'b11
   } irqc_sel_e;
endpackage

// File: rtl/irqc_evt_capture.sv
module irqc_evt_capture #(
   parameter int unsigned N_EVT        = 8,
   parameter bit          CAPTURE_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             clr_i,
   output logic [N_EVT-1:0] flag_q
);
   logic [N_EVT-1:0] set_c;

   generate
      if (CAPTURE_EDGE) begin : g_edge
         logic [N_EVT-1:0] prev_q;
         // prev starts all-ones: a source high at reset release is not an edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '1;
            else        prev_q <= evt_i;
         end
         assign set_c = evt_i & ~prev_q;
      end else begin : g_level
         assign set_c = evt_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= '0;
      else if (soft_rst) flag_q <= '0;
      else               flag_q <= (flag_q & ~{N_EVT{clr_i}}) | set_c;
   end
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
   import irqc_pkg::*;
#(
   parameter int unsigned N_EVT = 8,
   parameter int unsigned N_STS = 8,
   localparam int unsigned RD_W = (N_EVT > N_STS) ? N_EVT : N_STS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [IRQC_SEL_W-1:0] reg_addr,
   input  logic [N_EVT-1:0]      reg_wdata,
   input  logic [N_EVT-1:0]      flag_i,
   input  logic [N_STS-1:0]      sts_i,
   output logic [N_EVT-1:0]      en_q,
   output logic                  flag_clr,
   output logic [RD_W-1:0]       rdata_q
);
   irqc_sel_e sel;
   assign sel      = irqc_sel_e'(reg_addr);
   assign flag_clr = reg_rd && (sel == SEL_FLAGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           en_q <= '0;
      else if (soft_rst)                    en_q <= '0;
      else if (reg_wr && (sel == SEL_MASK)) en_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (reg_rd) begin
         case (sel)
            SEL_FLAGS: rdata_q <= RD_W'(flag_i);
            SEL_MASK:  rdata_q <= RD_W'(en_q);
            SEL_LIVE:  rdata_q <= RD_W'(sts_i);
            default:   rdata_q <= '0;
         endcase
      end
   end
endmodule

// File: rtl/irqc_line_drv.sv
module irqc_line_drv #(
   parameter int unsigned N_EVT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] flag_i,
   input  logic [N_EVT-1:0] en_i,
   output logic             irq_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n <= 1'b1;
      else        irq_n <= ~|(flag_i & en_i);
   end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned N_EVT        = 8,
   parameter int unsigned N_STS        = 8,
   parameter bit          CAPTURE_EDGE = 1'b1,
   localparam int unsigned RD_W = (N_EVT > N_STS) ? N_EVT : N_STS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [N_EVT-1:0]      evt_src,
   input  logic [N_STS-1:0]      sts_src,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [IRQC_SEL_W-1:0] reg_addr,
   input  logic [N_EVT-1:0]      reg_wdata,
   output logic [RD_W-1:0]       reg_rdata,
   output logic                  irq_n
);
   generate
      if (N_EVT < 1 || N_EVT > 32) begin : g_bad_evt
         $error("irq_status_ctrl: N_EVT must be in 1..32");
      end
      if (N_STS < 1 || N_STS > 32) begin : g_bad_sts
         $error("irq_status_ctrl: N_STS must be in 1..32");
      end
   endgenerate

   logic [N_EVT-1:0] flag_q;
   logic [N_EVT-1:0] en_q;
   logic             flag_clr;

   irqc_evt_capture #(.N_EVT(N_EVT), .CAPTURE_EDGE(CAPTURE_EDGE)) cap_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .evt_i(evt_src), .clr_i(flag_clr), .flag_q(flag_q)
   );

   irqc_regfile #(.N_EVT(N_EVT), .N_STS(N_STS)) regs_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .flag_i(flag_q), .sts_i(sts_src),
      .en_q(en_q), .flag_clr(flag_clr), .rdata_q(reg_rdata)
   );

   irqc_line_drv #(.N_EVT(N_EVT)) line_i (
      .clk(clk), .rst_n(rst_n), .flag_i(flag_q), .en_i(en_q), .irq_n(irq_n)
   );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int unsigned N_EVT        = 8,
   parameter int unsigned N_STS        = 8,
   parameter bit          CAPTURE_EDGE = 1'b1,
   localparam int unsigned RD_W = (N_EVT > N_STS) ? N_EVT : N_STS
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic [N_EVT-1:0] evt_src,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [1:0]       reg_addr,
   input logic [N_EVT-1:0] reg_wdata,
   input logic [RD_W-1:0]  reg_rdata,
   input logic             irq_n,
   input logic [N_EVT-1:0] flag_q,
   input logic [N_EVT-1:0] en_q
);
   logic [N_EVT-1:0] evt_d;
   logic [N_EVT-1:0] rise_c;
   logic             clr_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_d <= '1;
      else        evt_d <= evt_src;
   end
   assign rise_c = CAPTURE_EDGE ? (evt_src & ~evt_d) : evt_src;
   assign clr_c  = reg_rd && (reg_addr == 2'b00);

   AST_IRQ_FOLLOWS_MASKED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n == ~|($past(flag_q) & $past(en_q)))); // R6

   AST_FLAG_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      clr_c |=> (reg_rdata == RD_W'($past(flag_q)))); // R3

   AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      ((|rise_c) && !soft_rst) |=> ((flag_q & $past(rise_c)) == $past(rise_c))); // R4

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && !clr_c) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2

   AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (flag_q == '0 && en_q == '0)); // R8

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'b01 && !soft_rst) |=> (en_q == $past(reg_wdata))); // R5

   AST_OTHER_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != 2'b01 && !soft_rst) |=> (en_q == $past(en_q))); // R9
endmodule

bind irq_status_ctrl irqc_chk #(
   .N_EVT(N_EVT), .N_STS(N_STS), .CAPTURE_EDGE(CAPTURE_EDGE)
) chk_i (.*);

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/100ps
module irq_status_ctrl_tb_top;
   localparam int NE = 4;
   localparam int NS = 3;
   localparam int RW = 4;
   localparam logic [1:0] A_FLG = 2'b00, A_MSK = 2'b01, A_STS = 2'b10, A_NON = 2'b11;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, soft_rst, reg_wr, reg_rd, irq_n;
   logic [NE-1:0] evt_src, reg_wdata;
   logic [NS-1:0] sts_src;
   logic [1:0]    reg_addr;
   logic [RW-1:0] reg_rdata;
   logic [RW-1:0] d;

   int checks = 0;
   int fails  = 0;

   irq_status_ctrl #(.N_EVT(NE), .N_STS(NS), .CAPTURE_EDGE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .evt_src(evt_src),
      .sts_src(sts_src), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [NE-1:0] v);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [RW-1:0] v);
      reg_rd = 1'b1; reg_addr = a;
      tick();
      reg_rd = 1'b0;
      v = reg_rdata;
   endtask

   task automatic pulse(input logic [NE-1:0] p);
      evt_src = p;
      tick();
      evt_src = '0;
      tick();
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; soft_rst = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
      reg_addr = '0; reg_wdata = '0; sts_src = '0;
      evt_src = '1;
      repeat (3) tick();
      chk("R1 irq_n in reset", int'(irq_n), 1);
      chk("R1 rdata in reset", int'(reg_rdata), 0);
      rst_n = 1'b1;
      tick(); tick();
      rd(A_FLG, d); chk("R10 source high at release", int'(d), 0);
      rd(A_MSK, d); chk("R1 enable after reset", int'(d), 0);
      chk("R1 irq_n after reset", int'(irq_n), 1);
      evt_src = '0;
      tick();

      for (int m = 0; m < 16; m++) begin
         wr(A_MSK, NE'(m));
         rd(A_MSK, d);
         chk("R5 enable readback", int'(d), m);
      end

      for (int m = 0; m < 16; m++) begin
         wr(A_MSK, NE'(m));
         for (int p = 1; p < 16; p++) begin
            pulse(NE'(p));
            chk("R6 irq_n with flags", int'(irq_n), ((p & m) == 0) ? 1 : 0);
            rd(A_FLG, d);
            chk("R3 flag read data", int'(d), p);
            tick();
            chk("R6 irq_n after clear", int'(irq_n), 1);
         end
      end

      evt_src = 4'b0001;
      tick(); tick();
      rd(A_FLG, d); chk("R2 held source latched once", int'(d), 1);
      rd(A_FLG, d); chk("R2 held source no re-latch", int'(d), 0);
      evt_src = '0;
      tick();

      pulse(4'b0010);
      reg_rd = 1'b1; reg_addr = A_FLG; evt_src = 4'b0001;
      tick();
      reg_rd = 1'b0; evt_src = '0;
      chk("R4 same-cycle event not in read", int'(reg_rdata), 2);
      rd(A_FLG, d); chk("R4 same-cycle event kept", int'(d), 1);

      pulse(4'b0100);
      sts_src = 3'd5;
      rd(A_STS, d); chk("R7 status read", int'(d), 5);
      sts_src = 3'd2;
      rd(A_STS, d); chk("R7 status follows input", int'(d), 2);
      rd(A_MSK, d); chk("R5 enable kept", int'(d), 15);
      rd(A_FLG, d); chk("R7 flags untouched by other reads", int'(d), 4);

      wr(A_MSK, 4'hF);
      pulse(4'b0011);
      chk("R6 irq_n asserted", int'(irq_n), 0);
      soft_rst = 1'b1;
      tick();
      soft_rst = 1'b0;
      tick();
      chk("R8 irq_n released", int'(irq_n), 1);
      rd(A_MSK, d); chk("R8 enables cleared", int'(d), 0);
      rd(A_FLG, d); chk("R8 flags cleared", int'(d), 0);

      wr(A_MSK, 4'b0110);
      wr(A_FLG, 4'hF);
      wr(A_STS, 4'hF);
      wr(A_NON, 4'hF);
      rd(A_MSK, d); chk("R9 enable unchanged", int'(d), 6);
      rd(A_NON, d); chk("R9 unused select reads zero", int'(d), 0);
      rd(A_FLG, d); chk("R9 flag write ignored", int'(d), 0);
      chk("R9 irq_n idle", int'(irq_n), 1);

      pulse(4'b0001);
      tick();
      chk("R6 masked flag keeps line high", int'(irq_n), 1);
      rd(A_FLG, d); chk("R6 masked flag still latched", int'(d), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule